// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block sits between a set of peripheral interrupt lines and a small CPU. Every line owns an enable flag, a pending flag and a three-bit urgency level, where a smaller number is more urgent. Software configures the block through a single-cycle write port. It can switch lines on and off, raise or discard pending requests, store levels, choose how many level bits take part in preemption, set a masking threshold and open or close a master gate. One non-maskable input sits above all of this.

Each cycle the controller picks the most urgent eligible line and decides whether that line may interrupt the handler that is running now. If it may, the controller raises a request carrying the line index. An acknowledge from the CPU clears the pending flag and pushes the level onto a stack of active handlers. A return pulse pops that stack. The top entry of the stack is the current active level. An empty stack means no handler is active.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A level write (op code 4) to line i stores bits 7:5 of the write byte. Reading line i returns that level in bits 7:5, with bits 4:0 always zero, so level L reads as L×32.
- R2: Op code 0 sets the enable of line i and op code 1 clears it. A pending line that is disabled is never requested. Enabling it later makes it eligible.
- R3: A high cycle on a line input, or a pend-set write (op code 2), sets that line's pending flag whatever its enable. A line input that is high in the same cycle as an acknowledge or a software clear of that line leaves the flag set.
- R4: A pend-clear write (op code 3) discards a pending request that has not been serviced.
- R5: Among eligible lines, the smallest level wins. Equal levels go to the lowest index.
- R6: A threshold write (op code 6, value in bits 2:0) of M=0 masks nothing. For M from 1 to 7, lines whose level is M or above are not eligible.
- R7: A gate write (op code 7, bit 0) of 0 blocks every maskable request and leaves all enables unchanged. The non-maskable request ignores both the gate and the threshold.
- R8: An acknowledge while a request is up clears that request's pending flag. It also pushes the request's level, or a non-maskable marker, onto the active stack, and the top of the stack is shown on the active outputs.
- R9: A grouping write (op code 5, bits 2:0) of G keeps the top min(G,3) level bits as the preemption group. A winner is requested while a handler is active only if its group is strictly smaller than the active group. With G=0 nothing preempts, and values 3 to 7 all behave alike.
- R10: A return pulse pops the active stack. An empty stack reports no active handler. A return on an empty stack is ignored.
- R11: The non-maskable request is pended by its input or by a pend-set to index N. A pend-clear of it has no effect. It outranks every line, and nothing is requested while a non-maskable handler is active.
- R12: While the active stack is full, no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lines | input | NUM_LINES | Peripheral interrupt inputs; a high cycle pends the line |
| nmi_in | input | 1 | Non-maskable interrupt input |
| cfg_wr | input | 1 | Write strobe of the configuration port |
| cfg_op | input | 3 | Operation code |
| cfg_idx | input | IDX_W | Target line, or NUM_LINES for the non-maskable source |
| cfg_data | input | 8 | Write byte |
| rd_idx | input | IDX_W | Line selected for read-back |
| rd_level_byte | output | 8 | Level of the selected line, as L×32 |
| rd_pending | output | 1 | Pending flag of the selected line |
| rd_enabled | output | 1 | Enable flag of the selected line |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_req_nmi | output | 1 | The request is the non-maskable one |
| cpu_req_idx | output | IDX_W | Index of the requested source |
| cpu_ack | input | 1 | CPU takes the presented request |
| cpu_ret | input | 1 | CPU returns from the current handler |
| act_valid | output | 1 | A handler is active |
| act_nmi | output | 1 | The active handler is the non-maskable one |
| act_level | output | 3 | Level of the active handler |

## Verification
Two functions can meet in the same cycle and must be ordered. One is a line input that pends a request. The other is a clear of that same flag, either by acknowledge or by a software pend-clear. The bench drives the line high in the very cycle the CPU acknowledges it, and again in the cycle of a pend-clear write. It then reads the flag back and expects it still set, while the acknowledge has pushed the active stack as usual. Preemption against the group split and the full-stack block are provoked by building nested stacks level by level.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    OP_EN_SET   = 3'd0,
    OP_EN_CLR   = 3'd1,
    OP_PEND_SET = 3'd2,
    OP_PEND_CLR = 3'd3,
    OP_LEVEL    = 3'd4,
    OP_GROUP    = 3'd5,
    OP_THRESH   = 3'd6,
    OP_GATE     = 3'd7
  } cfg_op_e;

  typedef struct packed {
    logic is_nmi;
    lvl_t lvl;
  } act_ent_t;

  // number of level bits that act as preemption group
  function automatic int unsigned group_bits(input logic [2:0] g);
    return (int'(g) > LVL_W) ? LVL_W : int'(g);
  endfunction

  // preemption group value of a level
  function automatic lvl_t group_of(input lvl_t l, input int unsigned gb);
    return lvl_t'(l >> (LVL_W - gb));
  endfunction

  function automatic logic below_thresh(input lvl_t l, input lvl_t m);
    return (m == '0) || (l < m);
  endfunction

  function automatic lvl_t byte_to_lvl(input logic [7:0] b);
    return b[7:8-LVL_W];
  endfunction

  function automatic logic [7:0] lvl_to_byte(input lvl_t l);
    return {l, {(8-LVL_W){1'b0}}};
  endfunction
endpackage

// File: rtl/nic_line_bank.sv
module nic_line_bank
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0]            line_in,
  input  logic                            en_set,
  input  logic                            en_clr,
  input  logic                            pend_set,
  input  logic                            pend_clr,
  input  logic                            lvl_wr,
  input  logic [IDX_W-1:0]                sel_idx,
  input  lvl_t                            lvl_in,
  input  logic                            ack_clr,
  input  logic [IDX_W-1:0]                ack_idx,
  output logic [NUM_LINES-1:0]            pend_o,
  output logic [NUM_LINES-1:0]            en_o,
  output logic [NUM_LINES-1:0][LVL_W-1:0] lvl_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit, ack_hit, set_ev, clr_ev;
    assign hit     = (sel_idx == IDX_W'(i));
    assign ack_hit = ack_clr && (ack_idx == IDX_W'(i));
    assign set_ev  = line_in[i] || (pend_set && hit);
    assign clr_ev  = (pend_clr && hit) || ack_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_o[i] <= 1'b0;
        en_o[i]   <= 1'b0;
        lvl_o[i]  <= '0;
      end else begin
        if (set_ev)      pend_o[i] <= 1'b1;
        else if (clr_ev) pend_o[i] <= 1'b0;
        if (en_set && hit)      en_o[i] <= 1'b1;
        else if (en_clr && hit) en_o[i] <= 1'b0;
        if (lvl_wr && hit) lvl_o[i] <= lvl_in;
      end
    end

    // R3
    line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_in[i] |=> pend_o[i]);
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !line_in[i]) |=> !pend_o[i]);
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_LINES-1:0]            elig,
  input  logic [NUM_LINES-1:0][LVL_W-1:0] lvl,
  output logic                            win_valid,
  output logic [IDX_W-1:0]                win_idx,
  output lvl_t                            win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      // strict compare keeps the lowest index on equal levels
      if (elig[i] && (!win_valid || (lvl[i] < win_lvl))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/nic_active_stack.sv
module nic_active_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  act_ent_t push_ent,
  input  logic     pop,
  output logic     top_valid,
  output act_ent_t top_ent,
  output logic     full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  act_ent_t         ents [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] top_ptr;

  assign top_ptr   = PTR_W'(cnt - CNT_W'(1));
  assign top_valid = (cnt != '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign top_ent   = top_valid ? ents[top_ptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) ents[k] <= '0;
    end else begin
      if (push && pop && top_valid) begin
        ents[top_ptr] <= push_ent;
      end else if (push && !full) begin
        ents[PTR_W'(cnt)] <= push_ent;
        cnt <= cnt + CNT_W'(1);
      end else if (pop && top_valid) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !top_valid) |=> !top_valid);
  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> $stable(cnt));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int STACK_DEPTH = 9,
  localparam int IDX_W      = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 nmi_in,
  input  logic                 cfg_wr,
  input  logic [2:0]           cfg_op,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [7:0]           cfg_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [7:0]           rd_level_byte,
  output logic                 rd_pending,
  output logic                 rd_enabled,
  output logic                 cpu_req,
  output logic                 cpu_req_nmi,
  output logic [IDX_W-1:0]     cpu_req_idx,
  input  logic                 cpu_ack,
  input  logic                 cpu_ret,
  output logic                 act_valid,
  output logic                 act_nmi,
  output logic [2:0]           act_level
);
  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(NUM_LINES);

  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op);

  logic wr_en_set, wr_en_clr, wr_pend_set, wr_pend_clr, wr_lvl;
  assign wr_en_set   = cfg_wr && (op == OP_EN_SET);
  assign wr_en_clr   = cfg_wr && (op == OP_EN_CLR);
  assign wr_pend_set = cfg_wr && (op == OP_PEND_SET);
  assign wr_pend_clr = cfg_wr && (op == OP_PEND_CLR);
  assign wr_lvl      = cfg_wr && (op == OP_LEVEL);

  logic [2:0] group_q;
  lvl_t       thresh_q;
  logic       gate_q;
  logic       nmi_pend_q;

  logic [NUM_LINES-1:0]            pend, en, elig;
  logic [NUM_LINES-1:0][LVL_W-1:0] lvl;
  logic                            win_valid;
  logic [IDX_W-1:0]                win_idx;
  lvl_t                            win_lvl;
  logic                            stk_full, top_valid;
  act_ent_t                        top_ent, push_ent;

  // named internal events
  logic        ack_fire, ack_line, nmi_present, norm_present, preempt_ok;
  int unsigned gbits;

  assign ack_fire = cpu_ack && cpu_req;
  assign ack_line = ack_fire && !nmi_present;
  assign gbits    = group_bits(group_q);

  nic_line_bank #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (irq_lines),
    .en_set   (wr_en_set),
    .en_clr   (wr_en_clr),
    .pend_set (wr_pend_set),
    .pend_clr (wr_pend_clr),
    .lvl_wr   (wr_lvl),
    .sel_idx  (cfg_idx),
    .lvl_in   (byte_to_lvl(cfg_data)),
    .ack_clr  (ack_line),
    .ack_idx  (win_idx),
    .pend_o   (pend),
    .en_o     (en),
    .lvl_o    (lvl)
  );

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      elig[i] = pend[i] && en[i] && gate_q && below_thresh(lvl[i], thresh_q);
  end

  nic_arbiter #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arb (
    .elig      (elig),
    .lvl       (lvl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign preempt_ok = !top_valid ||
                      (!top_ent.is_nmi &&
                       (group_of(win_lvl, gbits) < group_of(top_ent.lvl, gbits)));
  assign nmi_present  = nmi_pend_q && !(top_valid && top_ent.is_nmi) && !stk_full;
  assign norm_present = win_valid && preempt_ok && !stk_full;

  assign cpu_req     = nmi_present || norm_present;
  assign cpu_req_nmi = nmi_present;
  assign cpu_req_idx = nmi_present ? NMI_IDX : win_idx;

  assign push_ent.is_nmi = nmi_present;
  assign push_ent.lvl    = nmi_present ? lvl_t'(0) : win_lvl;

  nic_active_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_fire),
    .push_ent  (push_ent),
    .pop       (cpu_ret),
    .top_valid (top_valid),
    .top_ent   (top_ent),
    .full      (stk_full)
  );

  assign act_valid = top_valid;
  assign act_nmi   = top_ent.is_nmi;
  assign act_level = top_ent.lvl;

  // configuration registers and the non-maskable pend flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      group_q    <= '0;
      thresh_q   <= '0;
      gate_q     <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      if (cfg_wr && op == OP_GROUP)  group_q  <= cfg_data[2:0];
      if (cfg_wr && op == OP_THRESH) thresh_q <= lvl_t'(cfg_data[2:0]);
      if (cfg_wr && op == OP_GATE)   gate_q   <= cfg_data[0];
      if (nmi_in || (wr_pend_set && cfg_idx == NMI_IDX)) nmi_pend_q <= 1'b1;
      else if (ack_fire && nmi_present)                  nmi_pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_level_byte = '0;
    rd_pending    = 1'b0;
    rd_enabled    = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_level_byte = lvl_to_byte(lvl[i]);
        rd_pending    = pend[i];
        rd_enabled    = en[i];
      end
    end
    if (rd_idx == NMI_IDX) rd_pending = nmi_pend_q;
  end

  // R12
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !stk_full);
  // R7
  gate_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_req_nmi) |-> gate_q);
  // R6
  thresh_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_req_nmi && thresh_q != '0) |-> (win_lvl < thresh_q));
  // R9
  no_group_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_req_nmi && act_valid) |-> (group_q != 3'd0));
  // R11
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend_q && !(ack_fire && cpu_req_nmi)) |=> nmi_pend_q);
  // R11
  nmi_active_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_nmi) |-> !cpu_req);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NL    = 8;
  localparam int DEPTH = 4;
  localparam int IW    = $clog2(NL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_lines = '0;
  logic          nmi_in = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_op = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0]    cfg_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0]    rd_level_byte;
  logic          rd_pending, rd_enabled;
  logic          cpu_req, cpu_req_nmi;
  logic [IW-1:0] cpu_req_idx;
  logic          cpu_ack = 1'b0, cpu_ret = 1'b0;
  logic          act_valid, act_nmi;
  logic [2:0]    act_level;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_P/2) clk = ~clk;

  nest_irq_ctrl #(.NUM_LINES(NL), .STACK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_in(nmi_in),
    .cfg_wr(cfg_wr), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rd_idx(rd_idx), .rd_level_byte(rd_level_byte), .rd_pending(rd_pending),
    .rd_enabled(rd_enabled), .cpu_req(cpu_req), .cpu_req_nmi(cpu_req_nmi),
    .cpu_req_idx(cpu_req_idx), .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
    .act_valid(act_valid), .act_nmi(act_nmi), .act_level(act_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int op, input int idx, input int data);
    cfg_wr = 1'b1; cfg_op = 3'(op); cfg_idx = IW'(idx); cfg_data = 8'(data);
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_lines(input logic [NL-1:0] m);
    irq_lines = m;
    step();
    irq_lines = '0;
  endtask

  task automatic pulse_nmi();
    nmi_in = 1'b1;
    step();
    nmi_in = 1'b0;
  endtask

  task automatic ack();
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
  endtask

  task automatic ret();
    cpu_ret = 1'b1;
    step();
    cpu_ret = 1'b0;
  endtask

  task automatic look(input int idx);
    rd_idx = IW'(idx);
    #1;
  endtask

  task automatic t_reset();
    look(0);
    chk("R10 reset act_valid", act_valid, 0);
    chk("R2 reset req", cpu_req, 0);
    chk("R1 reset level", rd_level_byte, 0);
    chk("R2 reset enable", rd_enabled, 0);
  endtask

  task automatic t_level();
    wr(4, 3, 8'hB7);
    look(3);
    chk("R1 level readback", rd_level_byte, 8'hA0);
    wr(4, 3, 8'h1F);
    look(3);
    chk("R1 low bits dropped", rd_level_byte, 0);
  endtask

  task automatic t_enable_pend();
    wr(7, 0, 1);
    pulse_lines(NL'(1 << 2));
    look(2);
    chk("R3 pend while disabled", rd_pending, 1);
    chk("R2 disabled no req", cpu_req, 0);
    wr(0, 2, 0);
    chk("R2 enabled req", cpu_req, 1);
    chk("R2 enabled idx", cpu_req_idx, 2);
    wr(1, 2, 0);
    look(2);
    chk("R2 enable cleared", rd_enabled, 0);
    chk("R2 cleared no req", cpu_req, 0);
    wr(0, 2, 0);
  endtask

  task automatic t_pend_clear();
    wr(3, 2, 0);
    look(2);
    chk("R4 pend discarded", rd_pending, 0);
    chk("R4 no req", cpu_req, 0);
  endtask

  task automatic t_arbitrate();
    wr(4, 5, 8'h40); wr(4, 6, 8'h40); wr(4, 1, 8'h80);
    wr(0, 5, 0); wr(0, 6, 0); wr(0, 1, 0);
    pulse_lines(NL'(8'b0110_0010));
    chk("R5 tie lowest idx", cpu_req_idx, 5);
    wr(3, 5, 0);
    chk("R5 next equal level", cpu_req_idx, 6);
    wr(3, 6, 0);
    chk("R5 remaining line", cpu_req_idx, 1);
  endtask

  task automatic t_thresh();
    wr(6, 0, 4);
    chk("R6 level at threshold masked", cpu_req, 0);
    wr(6, 0, 5);
    chk("R6 level below threshold", cpu_req, 1);
    wr(6, 0, 0);
    chk("R6 zero threshold", cpu_req, 1);
  endtask

  task automatic t_gate_nmi();
    wr(7, 0, 0);
    look(1);
    chk("R7 gate closed no req", cpu_req, 0);
    chk("R7 enable kept", rd_enabled, 1);
    wr(2, NL, 0);
    chk("R7 nmi through gate", cpu_req_nmi, 1);
    chk("R11 nmi idx", cpu_req_idx, NL);
    wr(3, NL, 0);
    look(NL);
    chk("R11 nmi clear ignored", rd_pending, 1);
    ack();
    chk("R8 nmi active", act_nmi, 1);
    chk("R8 nmi pend cleared", rd_pending, 0);
    pulse_nmi();
    chk("R11 no req under active nmi", cpu_req, 0);
    ret();
    chk("R11 pending nmi after return", cpu_req_nmi, 1);
    ack();
    ret();
    chk("R10 empty after returns", act_valid, 0);
    wr(7, 0, 1);
    chk("R7 gate reopened", cpu_req_idx, 1);
  endtask

  task automatic t_nest();
    wr(5, 0, 2);
    ack();
    look(1);
    chk("R8 active level", act_level, 4);
    chk("R8 pend auto clear", rd_pending, 0);
    wr(4, 2, 8'hA0); wr(4, 3, 8'h60); wr(0, 3, 0);
    pulse_lines(NL'(1 << 2));
    chk("R9 same group no preempt", cpu_req, 0);
    pulse_lines(NL'(1 << 3));
    chk("R9 smaller group preempts", cpu_req, 1);
    chk("R9 preempt idx", cpu_req_idx, 3);
    ack();
    chk("R8 nested level", act_level, 3);
    chk("R9 blocked under nested", cpu_req, 0);
    ret();
    chk("R10 pop to outer", act_level, 4);
    chk("R9 still blocked", cpu_req, 0);
    ret();
    chk("R10 empty", act_valid, 0);
    chk("R9 waiting line served", cpu_req_idx, 2);
    ack();
    ret();
  endtask

  task automatic t_group();
    wr(5, 0, 0);
    pulse_lines(NL'(1 << 1));
    ack();
    pulse_lines(NL'(1 << 3));
    chk("R9 grouping zero no preempt", cpu_req, 0);
    wr(5, 0, 6);
    chk("R9 grouping clamped", cpu_req, 1);
    wr(5, 0, 1);
    chk("R9 one group bit", cpu_req_idx, 3);
    wr(3, 3, 0);
    ret();
  endtask

  task automatic t_same_cycle();
    pulse_lines(NL'(1 << 2));
    chk("R3 req before collision", cpu_req_idx, 2);
    cpu_ack = 1'b1; irq_lines = NL'(1 << 2);
    step();
    cpu_ack = 1'b0; irq_lines = '0;
    look(2);
    chk("R3 line beats ack clear", rd_pending, 1);
    chk("R8 ack pushed", act_level, 5);
    cfg_wr = 1'b1; cfg_op = 3'd3; cfg_idx = IW'(2); irq_lines = NL'(1 << 2);
    step();
    cfg_wr = 1'b0; irq_lines = '0;
    chk("R3 line beats sw clear", rd_pending, 1);
    wr(3, 2, 0);
    ret();
  endtask

  task automatic t_full();
    wr(5, 0, 3);
    wr(0, 0, 0);
    for (int l = 7; l >= 4; l--) begin
      wr(4, 0, l * 32);
      pulse_lines(NL'(1));
      ack();
    end
    chk("R8 deepest level", act_level, 4);
    wr(4, 0, 8'h60);
    pulse_lines(NL'(1));
    chk("R12 full blocks line", cpu_req, 0);
    pulse_nmi();
    chk("R12 full blocks nmi", cpu_req, 0);
    ret();
    chk("R11 nmi first after pop", cpu_req_nmi, 1);
    ack();
    ret();
    chk("R9 line preempts level 5", cpu_req_idx, 0);
    ret(); ret(); ret();
    chk("R10 stack drained", act_valid, 0);
    wr(3, 0, 0);
    ret();
    chk("R10 extra return ignored", act_valid, 0);
    pulse_lines(NL'(1));
    ack();
    chk("R10 push after empty pop", act_level, 3);
    chk("R10 valid after push", act_valid, 1);
    ret();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_enable_pend();
    t_pend_clear();
    t_arbitrate();
    t_thresh();
    t_gate_nmi();
    t_nest();
    t_group();
    t_same_cycle();
    t_full();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule